// File: doc/BRIEF.md
# Measurement Reading Store Controller

This block manages a 2 KB byte-wide store made of two 1K x 8 banks. The low part of the store holds measurement readings. Each reading is a fixed four-byte record, and the block appends records in arrival order. The upper part is a scratchpad that a host reaches byte by byte. The block reports how many readings are held, whether the reading area is full, and whether an append was turned away because the area was full.

A host hands over a whole 32-bit reading in one request cycle. The controller then spends four cycles writing it, least significant byte first. A host can fetch any byte of any reading by giving the reading index and the byte number. A host can also read or write one scratchpad byte, given as an offset from the start of the scratchpad. Toward each bank the block drives active-low chip select, write enable and output enable, plus a shared ten-bit address and write byte. The bank arrays are modelled inside the block.

Top module: `reading_store`

## Requirements
- R1: After reset the block shows count 0, full, overflow, busy, error and read-valid all low, and every bank chip select, write enable and output enable high.
- R2: An accepted append writes bytes 0 to 3 of `app_data_i` (bits 7:0 first) to byte addresses 4n to 4n+3 on the four cycles after acceptance, where n is the count at acceptance. `busy_o` is high during those four cycles.
- R3: The count goes up by exactly one, on the edge that writes the fourth byte. It never exceeds 350, and `full_o` is high exactly when it equals 350.
- R4: An append while the count is 350 writes nothing. It sets `overflow_o`, which stays high until a clear is taken.
- R5: A read request for reading n (n < 350), byte k, returns the byte at address 4n+k on `rd_data_o`. `rd_valid_o` is high for one cycle, two edges after the request, and `busy_o` is high in the cycle between.
- R6: A read request with an index of 350 or more drives no bank strobe. It pulses `err_o` for one cycle after the request.
- R7: Scratchpad offset o addresses byte 1400+o. A write stores `sp_wdata_i` and a read returns the byte with the same timing as R5. An offset of 648 or more is rejected with an `err_o` pulse and no strobe.
- R8: Byte address bit 10 picks the bank (1 = upper bank), and bits 9:0 drive `bank_addr_o`. At most one chip select is low at a time.
- R9: A write cycle drives write enable low together with chip select, with output enable high. A read cycle drives output enable and chip select low, with write enable high. An idle cycle leaves all strobes high.
- R10: A clear taken while idle sets the count to zero and drops overflow. Memory contents are kept, so earlier readings still read back unchanged.
- R11: When several requests arrive together while idle, clear wins, then append, then read, then scratchpad. Requests that arrive while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Zero the reading count and overflow |
| app_valid_i | input | 1 | Append request |
| app_data_i | input | 32 | Reading to append |
| rd_req_i | input | 1 | Reading byte fetch request |
| rd_index_i | input | 9 | Reading index |
| rd_byte_i | input | 2 | Byte number within the reading |
| sp_req_i | input | 1 | Scratchpad access request |
| sp_we_i | input | 1 | Scratchpad access is a write |
| sp_off_i | input | 10 | Scratchpad byte offset |
| sp_wdata_i | input | 8 | Scratchpad write byte |
| busy_o | output | 1 | An access is in progress |
| count_o | output | 9 | Stored reading count |
| full_o | output | 1 | Reading area full |
| overflow_o | output | 1 | Sticky append-rejected flag |
| err_o | output | 1 | Out-of-range request pulse |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 8 | Read data |
| bank_cs_n_o | output | 2 | Per-bank chip select, active low |
| bank_we_n_o | output | 2 | Per-bank write enable, active low |
| bank_oe_n_o | output | 2 | Per-bank output enable, active low |
| bank_addr_o | output | 10 | Address within the bank |
| bank_wdata_o | output | 8 | Byte being written |

## Verification
A wrong append pointer or byte phase shows up in the same cycle as a wrong `bank_addr_o` or `bank_wdata_o`. It appears later as wrong data when the reading is fetched back. A count that is off by one shows on `count_o` right after the fourth write edge, and it moves the address of the next append. A wrong bank decode shows on the chip-select pair as soon as an access starts, and a corrupted byte surfaces two edges after the read request that touches it.

// File: rtl/rs_pkg.sv
package rs_pkg;

  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_APPEND = 2'd1,
    OP_READ   = 2'd2,
    OP_WRITE  = 2'd3
  } rs_op_e;

  // byte address of byte k inside record idx
  function automatic int unsigned rec_byte_addr(input int unsigned idx,
                                                input int unsigned k,
                                                input int unsigned rec_bytes);
    return idx * rec_bytes + k;
  endfunction

  // byte address of a scratchpad offset
  function automatic int unsigned sp_byte_addr(input int unsigned off,
                                               input int unsigned base);
    return base + off;
  endfunction

endpackage

// File: rtl/rs_mem_bank.sv
module rs_mem_bank #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          cs_n_i,
  input  logic          we_n_i,
  input  logic          oe_n_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!cs_n_i && !we_n_i) begin
      mem[addr_i] <= din_i;
    end else if (!cs_n_i && !oe_n_i) begin
      dout_o <= mem[addr_i];
    end
  end
endmodule

// File: rtl/rs_strobe.sv
module rs_strobe
  import rs_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_AW   = 10,
  parameter int ADDR_W    = 11
) (
  input  rs_op_e               op_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_BANKS-1:0] cs_n_o,
  output logic [NUM_BANKS-1:0] we_n_o,
  output logic [NUM_BANKS-1:0] oe_n_o,
  output logic [BANK_AW-1:0]   baddr_o
);
  localparam int SEL_W = ADDR_W - BANK_AW;

  logic             active;
  logic             wr_cycle;
  logic             rd_cycle;
  logic [SEL_W-1:0] sel;

  assign active   = (op_i != OP_IDLE);
  assign wr_cycle = (op_i == OP_APPEND) || (op_i == OP_WRITE);
  assign rd_cycle = (op_i == OP_READ);
  assign sel      = addr_i[ADDR_W-1 -: SEL_W];
  assign baddr_o  = addr_i[BANK_AW-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_strobe
    logic hit;
    assign hit       = active && (sel == SEL_W'(b));
    assign cs_n_o[b] = !hit;
    assign we_n_o[b] = !(hit && wr_cycle);
    assign oe_n_o[b] = !(hit && rd_cycle);
  end
endmodule

// File: rtl/rs_seq.sv
module rs_seq
  import rs_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int REC_BYTES = 4,
  parameter int REC_W     = 32,
  parameter int PH_W      = 2,
  parameter int MAX_REC   = 350,
  parameter int CNT_W     = 9,
  parameter int SPO_W     = 10,
  parameter int SP_BASE   = 1400,
  parameter int SP_BYTES  = 648,
  parameter int SEL_W     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              app_valid_i,
  input  logic [REC_W-1:0]  app_data_i,
  input  logic              rd_req_i,
  input  logic [CNT_W-1:0]  rd_index_i,
  input  logic [PH_W-1:0]   rd_byte_i,
  input  logic              sp_req_i,
  input  logic              sp_we_i,
  input  logic [SPO_W-1:0]  sp_off_i,
  input  logic [DATA_W-1:0] sp_wdata_i,
  output rs_op_e            op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wbyte_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              overflow_o,
  output logic              busy_o,
  output logic              rd_valid_o,
  output logic [SEL_W-1:0]  rd_bank_o,
  output logic              err_o,
  output logic              ev_app_accept_o,
  output logic              ev_app_reject_o,
  output logic              ev_app_done_o
);
  rs_op_e            op_q;
  logic [PH_W-1:0]   phase_q;
  logic [ADDR_W-1:0] addr_q;
  logic [REC_W-1:0]  data_q;
  logic [CNT_W-1:0]  count_q;
  logic              ovf_q;
  logic              rd_valid_q;
  logic [SEL_W-1:0]  rd_bank_q;
  logic              err_q;

  logic idle, full, rd_idx_ok, sp_ok;
  logic ev_clear, rd_sel, sp_sel;
  logic ev_rd_accept, ev_rd_reject, ev_sp_accept, ev_sp_reject;
  logic [ADDR_W-1:0] app_addr, rd_addr, sp_addr;

  assign idle      = (op_q == OP_IDLE);
  assign full      = (count_q == CNT_W'(MAX_REC));
  assign rd_idx_ok = (rd_index_i < CNT_W'(MAX_REC));
  assign sp_ok     = (sp_off_i < SPO_W'(SP_BYTES));

  // request arbitration while idle: clear, append, read, scratchpad
  assign ev_clear        = idle && clear_i;
  assign ev_app_accept_o = idle && !clear_i && app_valid_i && !full;
  assign ev_app_reject_o = idle && !clear_i && app_valid_i && full;
  assign rd_sel          = idle && !clear_i && !app_valid_i && rd_req_i;
  assign ev_rd_accept    = rd_sel && rd_idx_ok;
  assign ev_rd_reject    = rd_sel && !rd_idx_ok;
  assign sp_sel          = idle && !clear_i && !app_valid_i && !rd_req_i && sp_req_i;
  assign ev_sp_accept    = sp_sel && sp_ok;
  assign ev_sp_reject    = sp_sel && !sp_ok;
  assign ev_app_done_o   = (op_q == OP_APPEND) && (phase_q == PH_W'(REC_BYTES - 1));

  assign app_addr = ADDR_W'(rec_byte_addr(32'(count_q), 32'd0, REC_BYTES));
  assign rd_addr  = ADDR_W'(rec_byte_addr(32'(rd_index_i), 32'(rd_byte_i), REC_BYTES));
  assign sp_addr  = ADDR_W'(sp_byte_addr(32'(sp_off_i), SP_BASE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q       <= OP_IDLE;
      phase_q    <= '0;
      addr_q     <= '0;
      data_q     <= '0;
      count_q    <= '0;
      ovf_q      <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_bank_q  <= '0;
      err_q      <= 1'b0;
    end else begin
      rd_valid_q <= (op_q == OP_READ);
      err_q      <= ev_rd_reject || ev_sp_reject;
      if (op_q == OP_READ) begin
        rd_bank_q <= addr_q[ADDR_W-1 -: SEL_W];
      end
      case (op_q)
        OP_IDLE: begin
          if (ev_clear) begin
            count_q <= '0;
            ovf_q   <= 1'b0;
          end else if (ev_app_reject_o) begin
            ovf_q <= 1'b1;
          end else if (ev_app_accept_o) begin
            op_q    <= OP_APPEND;
            phase_q <= '0;
            addr_q  <= app_addr;
            data_q  <= app_data_i;
          end else if (ev_rd_accept) begin
            op_q   <= OP_READ;
            addr_q <= rd_addr;
          end else if (ev_sp_accept) begin
            op_q   <= sp_we_i ? OP_WRITE : OP_READ;
            addr_q <= sp_addr;
            data_q <= {{(REC_W - DATA_W){1'b0}}, sp_wdata_i};
          end
        end
        OP_APPEND: begin
          addr_q  <= addr_q + ADDR_W'(1);
          data_q  <= data_q >> DATA_W;
          phase_q <= phase_q + PH_W'(1);
          if (ev_app_done_o) begin
            op_q    <= OP_IDLE;
            count_q <= count_q + CNT_W'(1);
          end
        end
        default: op_q <= OP_IDLE;
      endcase
    end
  end

  assign op_o       = op_q;
  assign addr_o     = addr_q;
  assign wbyte_o    = data_q[DATA_W-1:0];
  assign count_o    = count_q;
  assign overflow_o = ovf_q;
  assign busy_o     = !idle;
  assign rd_valid_o = rd_valid_q;
  assign rd_bank_o  = rd_bank_q;
  assign err_o      = err_q;
endmodule

// File: rtl/reading_store.sv
module reading_store
  import rs_pkg::*;
#(
  parameter  int DATA_W     = 8,
  parameter  int BANK_AW    = 10,
  parameter  int NUM_BANKS  = 2,
  parameter  int REC_BYTES  = 4,
  parameter  int READ_AREA  = 1400,
  localparam int SEL_W      = $clog2(NUM_BANKS),
  localparam int ADDR_W     = BANK_AW + SEL_W,
  localparam int TOTAL      = NUM_BANKS << BANK_AW,
  localparam int MAX_REC    = READ_AREA / REC_BYTES,
  localparam int CNT_W      = $clog2(MAX_REC + 1),
  localparam int SP_BYTES   = TOTAL - READ_AREA,
  localparam int SPO_W      = $clog2(SP_BYTES),
  localparam int REC_W      = REC_BYTES * DATA_W,
  localparam int PH_W       = $clog2(REC_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_i,
  input  logic                 app_valid_i,
  input  logic [REC_W-1:0]     app_data_i,
  input  logic                 rd_req_i,
  input  logic [CNT_W-1:0]     rd_index_i,
  input  logic [PH_W-1:0]      rd_byte_i,
  input  logic                 sp_req_i,
  input  logic                 sp_we_i,
  input  logic [SPO_W-1:0]     sp_off_i,
  input  logic [DATA_W-1:0]    sp_wdata_i,
  output logic                 busy_o,
  output logic [CNT_W-1:0]     count_o,
  output logic                 full_o,
  output logic                 overflow_o,
  output logic                 err_o,
  output logic                 rd_valid_o,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic [NUM_BANKS-1:0] bank_cs_n_o,
  output logic [NUM_BANKS-1:0] bank_we_n_o,
  output logic [NUM_BANKS-1:0] bank_oe_n_o,
  output logic [BANK_AW-1:0]   bank_addr_o,
  output logic [DATA_W-1:0]    bank_wdata_o
);
  rs_op_e            op;
  logic [ADDR_W-1:0] addr;
  logic [SEL_W-1:0]  rd_bank;
  logic [DATA_W-1:0] bank_dout [NUM_BANKS];

  // internal events brought out for the checker
  logic ev_app_accept, ev_app_reject, ev_app_done;

  rs_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REC_BYTES(REC_BYTES), .REC_W(REC_W),
    .PH_W(PH_W), .MAX_REC(MAX_REC), .CNT_W(CNT_W), .SPO_W(SPO_W),
    .SP_BASE(READ_AREA), .SP_BYTES(SP_BYTES), .SEL_W(SEL_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
    .app_valid_i(app_valid_i), .app_data_i(app_data_i),
    .rd_req_i(rd_req_i), .rd_index_i(rd_index_i), .rd_byte_i(rd_byte_i),
    .sp_req_i(sp_req_i), .sp_we_i(sp_we_i), .sp_off_i(sp_off_i), .sp_wdata_i(sp_wdata_i),
    .op_o(op), .addr_o(addr), .wbyte_o(bank_wdata_o), .count_o(count_o),
    .overflow_o(overflow_o), .busy_o(busy_o), .rd_valid_o(rd_valid_o),
    .rd_bank_o(rd_bank), .err_o(err_o),
    .ev_app_accept_o(ev_app_accept), .ev_app_reject_o(ev_app_reject),
    .ev_app_done_o(ev_app_done)
  );

  rs_strobe #(
    .NUM_BANKS(NUM_BANKS), .BANK_AW(BANK_AW), .ADDR_W(ADDR_W)
  ) u_strobe (
    .op_i(op), .addr_i(addr),
    .cs_n_o(bank_cs_n_o), .we_n_o(bank_we_n_o), .oe_n_o(bank_oe_n_o),
    .baddr_o(bank_addr_o)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    rs_mem_bank #(.AW(BANK_AW), .DW(DATA_W)) u_bank (
      .clk(clk),
      .cs_n_i(bank_cs_n_o[b]),
      .we_n_i(bank_we_n_o[b]),
      .oe_n_i(bank_oe_n_o[b]),
      .addr_i(bank_addr_o),
      .din_i(bank_wdata_o),
      .dout_o(bank_dout[b])
    );
  end

  assign rd_data_o = bank_dout[rd_bank];
  assign full_o    = (count_o == CNT_W'(MAX_REC));
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int NUM_BANKS = 2,
  parameter int CNT_W     = 9,
  parameter int MAX_REC   = 350
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clear_i,
  input logic                 app_valid_i,
  input logic                 rd_req_i,
  input logic [CNT_W-1:0]     rd_index_i,
  input logic                 busy_o,
  input logic [CNT_W-1:0]     count_o,
  input logic                 overflow_o,
  input logic                 err_o,
  input logic                 rd_valid_o,
  input logic [NUM_BANKS-1:0] bank_cs_n_o,
  input logic [NUM_BANKS-1:0] bank_we_n_o,
  input logic [NUM_BANKS-1:0] bank_oe_n_o,
  input logic                 ev_app_accept,
  input logic                 ev_app_reject,
  input logic                 ev_app_done
);
  logic idle_rd;
  assign idle_rd = rd_req_i && !busy_o && !clear_i && !app_valid_i;

  assert_idle_strobes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (&bank_cs_n_o && &bank_we_n_o && &bank_oe_n_o));

  assert_append_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_app_accept |=> busy_o);

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_app_done |=> (count_o == $past(count_o) + CNT_W'(1)));

  assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_app_done && !(clear_i && !busy_o)) |=> $stable(count_o));

  assert_count_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CNT_W'(MAX_REC));

  assert_overflow_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_app_reject |=> overflow_o);

  assert_overflow_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow_o && !clear_i) |=> overflow_o);

  assert_read_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_rd && rd_index_i < CNT_W'(MAX_REC)) |=> busy_o ##1 rd_valid_o);

  assert_read_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_rd && rd_index_i >= CNT_W'(MAX_REC)) |=> (err_o && &bank_cs_n_o));

  assert_one_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~bank_cs_n_o) <= 1);

  assert_strobe_pairing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (((~bank_we_n_o) & bank_cs_n_o) == '0) && (((~bank_we_n_o) & (~bank_oe_n_o)) == '0));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && !busy_o) |=> (count_o == '0 && !overflow_o));
endmodule

bind reading_store rs_checker #(
  .NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W), .MAX_REC(MAX_REC)
) u_rs_checker (
  .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .app_valid_i(app_valid_i),
  .rd_req_i(rd_req_i), .rd_index_i(rd_index_i), .busy_o(busy_o),
  .count_o(count_o), .overflow_o(overflow_o), .err_o(err_o),
  .rd_valid_o(rd_valid_o), .bank_cs_n_o(bank_cs_n_o), .bank_we_n_o(bank_we_n_o),
  .bank_oe_n_o(bank_oe_n_o), .ev_app_accept(ev_app_accept),
  .ev_app_reject(ev_app_reject), .ev_app_done(ev_app_done)
);

// File: tb/test_reading_store.sv
module test_reading_store;
  logic clk = 0;
  logic rst_n = 0;
  logic clear_i = 0, app_valid_i = 0, rd_req_i = 0, sp_req_i = 0, sp_we_i = 0;
  logic [31:0] app_data_i = 0;
  logic [8:0]  rd_index_i = 0;
  logic [1:0]  rd_byte_i = 0;
  logic [9:0]  sp_off_i = 0;
  logic [7:0]  sp_wdata_i = 0;
  logic busy_o, full_o, overflow_o, err_o, rd_valid_o;
  logic [8:0] count_o;
  logic [7:0] rd_data_o, bank_wdata_o;
  logic [1:0] bank_cs_n_o, bank_we_n_o, bank_oe_n_o;
  logic [9:0] bank_addr_o;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  reading_store i_reading_store (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .app_valid_i(app_valid_i),
    .app_data_i(app_data_i), .rd_req_i(rd_req_i), .rd_index_i(rd_index_i),
    .rd_byte_i(rd_byte_i), .sp_req_i(sp_req_i), .sp_we_i(sp_we_i),
    .sp_off_i(sp_off_i), .sp_wdata_i(sp_wdata_i), .busy_o(busy_o),
    .count_o(count_o), .full_o(full_o), .overflow_o(overflow_o), .err_o(err_o),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .bank_cs_n_o(bank_cs_n_o),
    .bank_we_n_o(bank_we_n_o), .bank_oe_n_o(bank_oe_n_o),
    .bank_addr_o(bank_addr_o), .bank_wdata_o(bank_wdata_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  byte unsigned ref_mem [2048];
  int  m_count = 0, m_addr = 0, m_app_left = 0;
  bit  m_ovf = 0, m_op_rd = 0, m_op_wr = 0, m_rd_valid = 0, m_err = 0;
  bit [31:0] m_rec = 0;
  byte unsigned m_wbyte = 0, m_rd_data = 0;

  function automatic byte unsigned cur_app_byte();
    return m_rec[8*(4-m_app_left) +: 8];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_count = 0; m_ovf = 0; m_app_left = 0; m_op_rd = 0; m_op_wr = 0;
      m_rd_valid = 0; m_err = 0;
    end else begin
      m_rd_valid = 0;
      m_err = 0;
      if (m_app_left > 0) begin
        ref_mem[m_addr] = cur_app_byte();
        m_addr++;
        m_app_left--;
        if (m_app_left == 0) m_count++;
      end else if (m_op_rd) begin
        m_rd_valid = 1; m_rd_data = ref_mem[m_addr]; m_op_rd = 0;
      end else if (m_op_wr) begin
        ref_mem[m_addr] = m_wbyte; m_op_wr = 0;
      end else if (clear_i) begin
        m_count = 0; m_ovf = 0;
      end else if (app_valid_i) begin
        if (m_count == 350) m_ovf = 1;
        else begin m_app_left = 4; m_addr = 4 * m_count; m_rec = app_data_i; end
      end else if (rd_req_i) begin
        if (rd_index_i >= 350) m_err = 1;
        else begin m_op_rd = 1; m_addr = 4 * int'(rd_index_i) + int'(rd_byte_i); end
      end else if (sp_req_i) begin
        if (sp_off_i >= 648) m_err = 1;
        else begin
          m_addr = 1400 + int'(sp_off_i);
          if (sp_we_i) begin m_op_wr = 1; m_wbyte = sp_wdata_i; end
          else m_op_rd = 1;
        end
      end
      #5;
      compare_all();
    end
  end

  task automatic compare_all();
    bit act, wr;
    int bank;
    logic [1:0] ecs, ewe, eoe;
    act  = (m_app_left > 0) || m_op_rd || m_op_wr;
    wr   = (m_app_left > 0) || m_op_wr;
    bank = m_addr / 1024;
    ecs = 2'b11; ewe = 2'b11; eoe = 2'b11;
    if (act) ecs[bank] = 1'b0;
    if (act && wr) ewe[bank] = 1'b0;
    if (act && !wr) eoe[bank] = 1'b0;
    check("R3 count", count_o, m_count);
    check("R3 full", full_o, m_count == 350);
    check("R4 overflow", overflow_o, m_ovf);
    check("R2 busy", busy_o, act);
    check("R6 err", err_o, m_err);
    check("R5 rd_valid", rd_valid_o, m_rd_valid);
    if (m_rd_valid) check("R5 rd_data", rd_data_o, m_rd_data);
    check("R8 cs_n", bank_cs_n_o, ecs);
    check("R9 we_n", bank_we_n_o, ewe);
    check("R9 oe_n", bank_oe_n_o, eoe);
    if (act) check("R8 bank_addr", bank_addr_o, m_addr % 1024);
    if (m_app_left > 0) check("R2 wdata", bank_wdata_o, cur_app_byte());
    else if (m_op_wr) check("R7 wdata", bank_wdata_o, m_wbyte);
  endtask

  // ---------------- stimulus tasks ----------------
  task automatic do_append(input logic [31:0] d);
    @(negedge clk); app_valid_i = 1; app_data_i = d;
    @(negedge clk); app_valid_i = 0;
    if (busy_o) repeat (4) @(negedge clk);
  endtask

  task automatic do_read(input int idx, input int k, output int data);
    @(negedge clk); rd_req_i = 1; rd_index_i = 9'(idx); rd_byte_i = 2'(k);
    @(negedge clk); rd_req_i = 0;
    if (busy_o) begin @(negedge clk); data = int'(rd_data_o); end
    else data = -1;
  endtask

  task automatic do_sp(input bit we, input int off, input int wd, output int data);
    @(negedge clk); sp_req_i = 1; sp_we_i = we; sp_off_i = 10'(off); sp_wdata_i = 8'(wd);
    @(negedge clk); sp_req_i = 0; sp_we_i = 0;
    data = -1;
    if (busy_o) begin @(negedge clk); if (!we) data = int'(rd_data_o); end
  endtask

  function automatic logic [31:0] pat(input int n);
    return 32'h1F2E3D4C ^ (32'(n) * 32'h01010101) ^ {8'(n), 24'h0};
  endfunction

  initial begin : watchdog
    #(20 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int d;
    int saw_valid;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 count", count_o, 0);
    check("R1 busy", busy_o, 0);
    check("R1 flags", {full_o, overflow_o, err_o, rd_valid_o}, 0);
    check("R1 strobes", {bank_cs_n_o, bank_we_n_o, bank_oe_n_o}, 6'h3F);
    rst_n = 1;

    // R2/R5: a few readings, read back byte by byte
    do_append(32'hDDCCBBAA);
    do_append(32'h44332211);
    do_append(32'h00FF807F);
    do_read(0, 0, d); check("R2 lsb first", d, 8'hAA);
    do_read(0, 3, d); check("R2 msb last", d, 8'hDD);
    do_read(1, 2, d); check("R5 byte k of n", d, 8'h33);
    do_read(2, 1, d); check("R5 byte k of n", d, 8'h80);
    check("R3 count after three", count_o, 3);

    // R6: out-of-range reading index
    do_read(350, 0, d); check("R6 reject no data", d, -1);
    do_read(511, 2, d); check("R6 reject no data", d, -1);

    // R7: scratchpad edges and reject
    do_sp(1, 0, 8'h5A, d);
    do_sp(1, 647, 8'hC3, d);
    do_sp(1, 648, 8'h99, d);
    do_sp(0, 0, 0, d);   check("R7 sp first", d, 8'h5A);
    do_sp(0, 647, 0, d); check("R7 sp last", d, 8'hC3);
    do_sp(0, 1000, 0, d); check("R7 sp reject", d, -1);

    // R11: simultaneous append + read -> append wins
    @(negedge clk); app_valid_i = 1; app_data_i = 32'h0BADF00D; rd_req_i = 1; rd_index_i = 0;
    @(negedge clk); app_valid_i = 0; rd_req_i = 0;
    check("R11 append first", busy_o, 1);
    saw_valid = 0;
    // R11: requests while busy are ignored
    rd_req_i = 1; rd_index_i = 1; sp_req_i = 1; sp_we_i = 1; sp_off_i = 0; sp_wdata_i = 8'h00;
    repeat (3) begin @(negedge clk); saw_valid += int'(rd_valid_o); end
    rd_req_i = 0; sp_req_i = 0; sp_we_i = 0;
    repeat (2) begin @(negedge clk); saw_valid += int'(rd_valid_o); end
    check("R11 busy ignores", saw_valid, 0);
    check("R11 count", count_o, 4);
    do_sp(0, 0, 0, d); check("R11 sp untouched", d, 8'h5A);

    // R10: clear beats append and keeps memory
    @(negedge clk); clear_i = 1; app_valid_i = 1;
    @(negedge clk); clear_i = 0; app_valid_i = 0;
    check("R10 count zero", count_o, 0);
    check("R11 clear wins", busy_o, 0);
    do_read(1, 0, d); check("R10 memory kept", d, 8'h11);

    // R3/R8: fill to 350, crossing into the upper bank
    for (int n = 0; n < 350; n++) do_append(pat(n));
    check("R3 full count", count_o, 350);
    check("R3 full flag", full_o, 1);
    do_read(256, 0, d); check("R8 upper bank", d, int'(pat(256) & 32'hFF));
    do_read(255, 3, d); check("R8 lower bank top", d, int'(pat(255) >> 24));
    do_read(349, 3, d); check("R5 last byte", d, int'(pat(349) >> 24));

    // R4: append when full
    do_append(32'hFFFFFFFF);
    check("R4 overflow set", overflow_o, 1);
    check("R4 count held", count_o, 350);
    do_read(349, 0, d); check("R4 memory unchanged", d, int'(pat(349) & 32'hFF));
    do_sp(0, 0, 0, d); check("R4 sp unchanged", d, 8'h5A);
    repeat (3) @(negedge clk);
    check("R4 overflow sticky", overflow_o, 1);
    @(negedge clk); clear_i = 1;
    @(negedge clk); clear_i = 0;
    check("R10 overflow cleared", overflow_o, 0);
    check("R10 count cleared", count_o, 0);
    do_read(100, 2, d); check("R10 data kept", d, int'((pat(100) >> 16) & 32'hFF));

    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule